// File: doc/BRIEF.md
# Serial Command Slave with Configuration Register

This block is the target end of a four-wire serial link (select, clock, data in, data out) in front of a multichannel recording front end. The host clocks in a 22-bit frame for each transaction. The first two bits are an opcode. The following twenty bits are a payload. Depending on the opcode, the block stores the payload as the new configuration, returns the present configuration, returns the latest acquisition packet, or does nothing.

The stored configuration drives the analog side through three decoded fields: a parity-append enable, a selector enable and a gain code. The field sense is chosen so that an all-zero register is a safe, working setting. In that setting the selector runs, the gain is unity and no parity is appended.

The serial lines are oversampled by the local clock, so the host link must run at most one quarter of that clock rate. The acquisition packet is 22 bits long. When parity is enabled, sixteen parity bits are appended and the packet grows to 38 bits.

Top module: `spiCmdSlave`

## Requirements
- R1: While `rstN` is low, and after it is released, the configuration is all zero: `eccEnable`=0, `muxEnable`=1, `gainCode`=0 and `miso`=0. A configuration read then returns twenty zero bits.
- R2: Opcode `01` writes the 20 payload bits, most significant first, into the configuration register once the 22nd rising clock edge is seen. Field positions: bit 0 is the parity enable (`eccEnable`), bit 1 is a selector disable (`muxEnable` is its inverse), and bits 5:2 are `gainCode`. Bits 19:6 are stored and read back.
- R3: Data is taken from `mosi` on rising `sclk` edges and changes on `miso` only after falling edges. For opcode `11`, the host samples the configuration bit 19 first on the 3rd rising edge, then the remaining bits down to bit 0, then zeros.
- R4: For opcode `10` with parity disabled, the host samples 22 bits from the 3rd rising edge: the first-channel flag, a 0 parity-active flag, then `sampleIn[19:0]` most significant first. After these, `miso` stays 0.
- R5: For opcode `10` with parity enabled, the parity-active flag is 1 and the packet continues with `parityIn[15:0]`, most significant first, for 38 bits in all.
- R6: The acquisition packet is captured when the opcode's second bit arrives. Input changes later in the frame do not alter the bits sent.
- R7: Raising `csN` before the 22nd rising edge discards the partial frame. The configuration keeps its old value.
- R8: Opcode `00` leaves the configuration unchanged and returns only zeros on `miso`.
- R9: While `csN` is high, `miso` is 0, at most a few local clocks after `csN` rises.
- R10: Clock edges beyond the 22nd in a write frame do not change the committed configuration.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Local clock that oversamples the serial lines |
| rstN | input | 1 | Global reset, active low, asynchronous assert; may be tied high |
| sclk | input | 1 | Serial clock from the host |
| csN | input | 1 | Chip select, active low |
| mosi | input | 1 | Serial data from the host |
| miso | output | 1 | Serial data to the host |
| firstChan | input | 1 | Set when the current sample pair holds channel 1 |
| sampleIn | input | 20 | Two 10-bit conversion results |
| parityIn | input | 16 | Parity word for the current sample pair |
| eccEnable | output | 1 | Parity append enabled |
| muxEnable | output | 1 | Channel selector running |
| gainCode | output | 4 | Post-amplifier gain code, 0 is unity |

## Verification
A wrong bit counter or opcode register shows up within one frame. A read returns its first bit one slot early or late, or a write lands shifted by a bit. Both appear at the next configuration read or on the decoded field outputs right after the 22nd edge. A missed snapshot or a stale transmit register shows as wrong `miso` bits in the same frame. A leftover transmit register after an abort shows as `miso` not returning to zero a few clocks after select is released. Every transaction is therefore followed by field checks and a read-back, so any stored corruption is exposed within one further frame.

// File: rtl/spiCmdPkg.sv
package spiCmdPkg;
  localparam int OP_W = 2;

  typedef enum logic [OP_W-1:0] {
    OP_IDLE  = 2'b00,
    OP_WRITE = 2'b01,
    OP_ACQ   = 2'b10,
    OP_CFGRD = 2'b11
  } opcode_e;

  // strobes from control to datapath, one local-clock wide
  typedef struct packed {
    logic clearAll;
    logic shiftIn;
    logic shiftOut;
    logic loadAcq;
    logic loadCfg;
    logic commitCfg;
  } strobes_t;
endpackage

// File: rtl/spiSync.sv
module spiSync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic sclkIn,
  input  logic csNIn,
  input  logic mosiIn,
  output logic sclkRise,
  output logic sclkFall,
  output logic csIdle,
  output logic mosiS
);
  localparam int NL = 3;
  localparam int L_MOSI = 0;
  localparam int L_SCLK = 1;
  localparam int L_CS   = 2;

  logic [NL-1:0] rawIn;
  logic [NL-1:0] rstVal;
  logic [STAGES:0] pipe [NL];

  assign rawIn  = {csNIn, sclkIn, mosiIn};
  assign rstVal = 3'b100;  // select idles high

  for (genvar g = 0; g < NL; g++) begin : gLine
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) pipe[g] <= {(STAGES+1){rstVal[g]}};
      else       pipe[g] <= {pipe[g][STAGES-1:0], rawIn[g]};
    end
  end

  assign sclkRise = pipe[L_SCLK][STAGES-1] & ~pipe[L_SCLK][STAGES];
  assign sclkFall = ~pipe[L_SCLK][STAGES-1] & pipe[L_SCLK][STAGES];
  assign csIdle   = pipe[L_CS][STAGES-1];
  assign mosiS    = pipe[L_MOSI][STAGES-1];
endmodule

// File: rtl/spiCtrl.sv
module spiCtrl
  import spiCmdPkg::*;
#(
  parameter int FRAME_W = 22
) (
  input  logic     clk,
  input  logic     rstN,
  input  logic     sclkRise,
  input  logic     sclkFall,
  input  logic     csIdle,
  input  logic     mosiS,
  output strobes_t strb
);
  localparam int CNT_W = $clog2(FRAME_W + 1);
  localparam logic [CNT_W-1:0] OP_LAST  = CNT_W'(OP_W - 1);
  localparam logic [CNT_W-1:0] FR_LAST  = CNT_W'(FRAME_W - 1);
  localparam logic [CNT_W-1:0] FR_FULL  = CNT_W'(FRAME_W);

  logic [CNT_W-1:0] bitCnt;
  logic [OP_W-1:0]  opShift;
  opcode_e          opReg;
  opcode_e          opNow;
  logic             risePhase;
  logic             opDone;

  assign opNow     = opcode_e'({opShift[OP_W-2:0], mosiS});
  assign risePhase = !csIdle && sclkRise;
  assign opDone    = risePhase && (bitCnt == OP_LAST);

  always_comb begin
    strb           = '0;
    strb.clearAll  = csIdle;
    strb.shiftIn   = risePhase;
    strb.shiftOut  = !csIdle && sclkFall;
    strb.loadAcq   = opDone && (opNow == OP_ACQ);
    strb.loadCfg   = opDone && (opNow == OP_CFGRD);
    strb.commitCfg = risePhase && (bitCnt == FR_LAST) && (opReg == OP_WRITE);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bitCnt  <= '0;
      opShift <= '0;
      opReg   <= OP_IDLE;
    end else if (csIdle) begin
      bitCnt  <= '0;
      opShift <= '0;
      opReg   <= OP_IDLE;
    end else if (risePhase) begin
      if (bitCnt != FR_FULL) bitCnt <= bitCnt + 1'b1;
      if (bitCnt < CNT_W'(OP_W)) opShift <= {opShift[OP_W-2:0], mosiS};
      if (opDone) opReg <= opNow;
    end
  end
endmodule

// File: rtl/spiDatapath.sv
module spiDatapath
  import spiCmdPkg::*;
#(
  parameter int CFG_W    = 20,
  parameter int SAMPLE_W = 20,
  parameter int PAR_W    = 16,
  parameter int ECC_BIT  = 0
) (
  input  logic                clk,
  input  logic                rstN,
  input  strobes_t            strb,
  input  logic                mosiS,
  input  logic                firstChan,
  input  logic [SAMPLE_W-1:0] sampleIn,
  input  logic [PAR_W-1:0]    parityIn,
  output logic                miso,
  output logic [CFG_W-1:0]    cfgQ
);
  localparam int PKT_W = 2 + SAMPLE_W + PAR_W;
  localparam int TX_W  = (PKT_W > CFG_W) ? PKT_W : CFG_W;

  logic [CFG_W-1:0] rxShift;
  logic [TX_W-1:0]  txShift;
  logic [PKT_W-1:0] acqWord;
  logic             eccOn;
  logic             misoQ;

  assign eccOn   = cfgQ[ECC_BIT];
  assign acqWord = {firstChan, eccOn, sampleIn, eccOn ? parityIn : {PAR_W{1'b0}}};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxShift <= '0;
      cfgQ    <= '0;
    end else begin
      if (strb.clearAll)     rxShift <= '0;
      else if (strb.shiftIn) rxShift <= {rxShift[CFG_W-2:0], mosiS};
      if (strb.commitCfg)    cfgQ    <= {rxShift[CFG_W-2:0], mosiS};
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txShift <= '0;
      misoQ   <= 1'b0;
    end else if (strb.clearAll) begin
      txShift <= '0;
      misoQ   <= 1'b0;
    end else if (strb.loadAcq) begin
      txShift <= TX_W'(acqWord) << (TX_W - PKT_W);
    end else if (strb.loadCfg) begin
      txShift <= TX_W'(cfgQ) << (TX_W - CFG_W);
    end else if (strb.shiftOut) begin
      misoQ   <= txShift[TX_W-1];
      txShift <= txShift << 1;
    end
  end

  assign miso = misoQ;
endmodule

// File: rtl/spiCmdSlave.sv
module spiCmdSlave
  import spiCmdPkg::*;
#(
  parameter int CFG_W       = 20,
  parameter int SAMPLE_W    = 20,
  parameter int PAR_W       = 16,
  parameter int GAIN_W      = 4,
  parameter int ECC_BIT     = 0,
  parameter int SEL_BIT     = 1,
  parameter int GAIN_LSB    = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                sclk,
  input  logic                csN,
  input  logic                mosi,
  output logic                miso,
  input  logic                firstChan,
  input  logic [SAMPLE_W-1:0] sampleIn,
  input  logic [PAR_W-1:0]    parityIn,
  output logic                eccEnable,
  output logic                muxEnable,
  output logic [GAIN_W-1:0]   gainCode
);
  localparam int FRAME_W = OP_W + CFG_W;

  logic             sclkRise;
  logic             sclkFall;
  logic             csIdle;
  logic             mosiS;
  strobes_t         strb;
  logic [CFG_W-1:0] cfgQ;

  spiSync #(.STAGES(SYNC_STAGES)) uSync (
    .clk(clk), .rstN(rstN), .sclkIn(sclk), .csNIn(csN), .mosiIn(mosi),
    .sclkRise(sclkRise), .sclkFall(sclkFall), .csIdle(csIdle), .mosiS(mosiS)
  );

  spiCtrl #(.FRAME_W(FRAME_W)) uCtrl (
    .clk(clk), .rstN(rstN), .sclkRise(sclkRise), .sclkFall(sclkFall),
    .csIdle(csIdle), .mosiS(mosiS), .strb(strb)
  );

  spiDatapath #(
    .CFG_W(CFG_W), .SAMPLE_W(SAMPLE_W), .PAR_W(PAR_W), .ECC_BIT(ECC_BIT)
  ) uData (
    .clk(clk), .rstN(rstN), .strb(strb), .mosiS(mosiS), .firstChan(firstChan),
    .sampleIn(sampleIn), .parityIn(parityIn), .miso(miso), .cfgQ(cfgQ)
  );

  // zero register means: no parity, selector running, unity gain
  assign eccEnable = cfgQ[ECC_BIT];
  assign muxEnable = ~cfgQ[SEL_BIT];
  assign gainCode  = cfgQ[GAIN_LSB +: GAIN_W];
endmodule

// File: rtl/spiCmdSlaveChk.sv
module spiCmdSlaveChk
  import spiCmdPkg::*;
#(
  parameter int GAIN_W = 4
) (
  input logic              clk,
  input logic              rstN,
  input logic              miso,
  input logic              eccEnable,
  input logic              muxEnable,
  input logic [GAIN_W-1:0] gainCode,
  input strobes_t          strb,
  input logic              sclkFall,
  input logic              csIdle
);
  // R1: fields leave reset at their defaults
  a_r1_reset_defaults: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> (!eccEnable && muxEnable && gainCode == '0 && !miso));

  // R2, R7, R8, R10: fields move only after a commit strobe
  a_r2_fields_hold: assert property (@(posedge clk) disable iff (!rstN)
    !strb.commitCfg |=> $stable({eccEnable, muxEnable, gainCode}));

  // R3: data out changes only after a falling serial edge while selected
  a_r3_out_on_fall: assert property (@(posedge clk) disable iff (!rstN)
    (!sclkFall && !csIdle) |=> $stable(miso));

  // R9: output quiet while deselected
  a_r9_out_quiet: assert property (@(posedge clk) disable iff (!rstN)
    csIdle |=> !miso);

  // R6: at most one load or commit action per local clock
  a_r6_single_load: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.loadAcq, strb.loadCfg, strb.commitCfg}));
endmodule

bind spiCmdSlave spiCmdSlaveChk #(.GAIN_W(GAIN_W)) uChk (
  .clk(clk), .rstN(rstN), .miso(miso), .eccEnable(eccEnable),
  .muxEnable(muxEnable), .gainCode(gainCode), .strb(strb),
  .sclkFall(sclkFall), .csIdle(csIdle)
);

// File: tb/tb_spiCmdSlave.sv
module tb_spiCmdSlave;
  localparam int HALF  = 6;
  localparam int NVEC  = 8;
  localparam int LIMIT = 200000;

  typedef struct packed {
    logic [1:0]  op;
    logic [19:0] data;
    logic [5:0]  nClk;
    logic        fc;
    logic [19:0] smp;
    logic [15:0] par;
  } vec_t;

  localparam vec_t VEC [NVEC] = '{
    '{2'b11, 20'h00000, 6'd22, 1'b0, 20'h00000, 16'h0000},  // R1 read-back after reset
    '{2'b01, 20'h9A5B6, 6'd22, 1'b0, 20'h00000, 16'h0000},  // R2 write
    '{2'b11, 20'h00000, 6'd24, 1'b0, 20'h00000, 16'h0000},  // R3 read config
    '{2'b10, 20'h00000, 6'd40, 1'b1, 20'hC3A51, 16'hBEEF},  // R4 acq, no parity
    '{2'b01, 20'h00015, 6'd40, 1'b0, 20'h00000, 16'h0000},  // R10 write with trailing ones
    '{2'b10, 20'h00000, 6'd40, 1'b0, 20'h5A5A5, 16'h1234},  // R5 acq with parity
    '{2'b00, 20'hFFFFF, 6'd22, 1'b1, 20'hFFFFF, 16'hFFFF},  // R8 idle
    '{2'b11, 20'h00000, 6'd22, 1'b0, 20'h00000, 16'h0000}   // R3 read config again
  };

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rstN, sclk, csN, mosi, firstChan;
  logic [19:0] sampleIn;
  logic [15:0] parityIn;
  logic miso, eccEnable, muxEnable;
  logic [3:0] gainCode;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;
  logic [19:0] modelCfg;

  spiCmdSlave dut (
    .clk(clk), .rstN(rstN), .sclk(sclk), .csN(csN), .mosi(mosi), .miso(miso),
    .firstChan(firstChan), .sampleIn(sampleIn), .parityIn(parityIn),
    .eccEnable(eccEnable), .muxEnable(muxEnable), .gainCode(gainCode)
  );

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [37:0] expResp(logic [1:0] op, logic [19:0] cfg, logic fc,
                                          logic [19:0] s, logic [15:0] p);
    case (op)
      2'b10:   return {fc, cfg[0], s, cfg[0] ? p : 16'h0};
      2'b11:   return {cfg, 18'h0};
      default: return '0;
    endcase
  endfunction

  task automatic checkFields(input string req);
    logic [5:0] act, exp;
    act = {eccEnable, muxEnable, gainCode};
    exp = {modelCfg[0], ~modelCfg[1], modelCfg[5:2]};
    check(act == exp, req, 64'(act), 64'(exp));
  endtask

  // one framed transaction; host samples miso just before each rising edge
  task automatic xfer(input logic [1:0] op, input logic [19:0] d, input int nClk,
                      input int flipAt, output logic [37:0] resp);
    logic [21:0] frame;
    frame = {op, d};
    resp  = '0;
    csN = 1'b0;
    repeat (HALF) @(negedge clk);
    for (int i = 0; i < nClk; i++) begin
      mosi = (i < 22) ? frame[21-i] : 1'b1;
      repeat (HALF) @(negedge clk);
      if (i >= 2 && i < 40) resp[39-i] = miso;
      sclk = 1'b1;
      repeat (HALF) @(negedge clk);
      if (i == flipAt) begin
        sampleIn  = ~sampleIn;
        parityIn  = ~parityIn;
        firstChan = ~firstChan;
      end
      sclk = 1'b0;
    end
    repeat (HALF) @(negedge clk);
    csN  = 1'b1;
    mosi = 1'b0;
    repeat (2*HALF) @(negedge clk);
  endtask

  initial begin
    for (int c = 0; c < LIMIT; c++) begin
      @(posedge clk);
      if (finished) break;
    end
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [37:0] resp, exp;
    string tag;
    rstN = 1'b0; sclk = 1'b0; csN = 1'b1; mosi = 1'b0;
    firstChan = 1'b0; sampleIn = '0; parityIn = '0;
    modelCfg = '0;
    repeat (5) @(negedge clk);
    checkFields("R1 during reset");
    rstN = 1'b1;
    repeat (5) @(negedge clk);
    checkFields("R1 after reset");
    check(miso == 1'b0, "R9 idle after reset", 64'(miso), 64'(0));

    for (int v = 0; v < NVEC; v++) begin
      firstChan = VEC[v].fc;
      sampleIn  = VEC[v].smp;
      parityIn  = VEC[v].par;
      exp = expResp(VEC[v].op, modelCfg, VEC[v].fc, VEC[v].smp, VEC[v].par);
      xfer(VEC[v].op, VEC[v].data, int'(VEC[v].nClk), -1, resp);
      case (VEC[v].op)
        2'b11:   tag = "R3 config read";
        2'b10:   tag = modelCfg[0] ? "R5 acq with parity" : "R4 acq without parity";
        2'b01:   tag = "R2 write response";
        default: tag = "R8 idle response";
      endcase
      check(resp == exp, tag, 64'(resp), 64'(exp));
      if (VEC[v].op == 2'b01 && VEC[v].nClk >= 22) modelCfg = VEC[v].data;
      checkFields((VEC[v].nClk > 22) ? "R10 fields after long frame" : "R2 fields");
    end

    // R6: inputs change mid-read, sent packet keeps the captured values
    firstChan = 1'b1; sampleIn = 20'h0F0F3; parityIn = 16'hA5C3;
    exp = expResp(2'b10, modelCfg, 1'b1, 20'h0F0F3, 16'hA5C3);
    xfer(2'b10, 20'h0, 40, 1, resp);
    check(resp == exp, "R6 snapshot", 64'(resp), 64'(exp));

    // R7: aborted write leaves configuration alone
    xfer(2'b01, 20'hFFFFF, 15, -1, resp);
    checkFields("R7 fields after abort");
    xfer(2'b11, 20'h0, 22, -1, resp);
    exp = expResp(2'b11, modelCfg, 1'b0, 20'h0, 16'h0);
    check(resp == exp, "R7 read after abort", 64'(resp), 64'(exp));

    // R9: read of all-ones config cut short, miso must drop
    xfer(2'b01, 20'hFFFF3, 22, -1, resp);
    modelCfg = 20'hFFFF3;
    checkFields("R2 fields all ones");
    xfer(2'b11, 20'h0, 8, -1, resp);
    check(resp[37:32] == 6'h3F, "R3 partial read bits", 64'(resp[37:32]), 64'(6'h3F));
    check(miso == 1'b0, "R9 quiet after abort", 64'(miso), 64'(0));

    // R1: global reset restores defaults
    rstN = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    modelCfg = '0;
    repeat (3) @(negedge clk);
    checkFields("R1 after global reset");
    xfer(2'b11, 20'h0, 22, -1, resp);
    check(resp == 38'h0, "R1 read after global reset", 64'(resp), 64'(0));

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule